// File: doc/BRIEF.md
# Transfer Negotiation Message Builder

This block composes one extended negotiation message (bus width or synchronous transfer) and writes it byte by byte into a message buffer for a single target. The caller states which negotiation it wants and supplies the target's scratch byte, which packs a width flag, a rate index and an offset. It also supplies the ultra-speed setting, the present bus width, and whether this side opens the negotiation or answers the target. The caller also gives the number of bytes already in the buffer, such as an identify or tag message, so that the new message follows them.

Once a request is accepted, the block emits one buffer write per cycle at consecutive addresses. It then publishes the new total buffer length together with a one-cycle done pulse. The synchronous period byte is derived from the rate index with shift-and-add arithmetic, with no multiplier. The offset byte comes either from a bus-width-dependent maximum or from the scratch byte. A request that arrives while a message is still being produced is refused and flagged.

Top module: `neg_msg_builder`

## Requirements
- R1: After reset, wr_en, done and busy_err are low and msg_len is zero.
- R2: A width message is four writes in consecutive cycles, starting the cycle after the accepted request, at addresses base_len to base_len+3. The data is 0x01, 0x02, 0x03, then the width code. The width code is 0x01 (16-bit) when scratch bit 7 is set and 0x00 (8-bit) otherwise.
- R3: A synchronous message is five writes in consecutive cycles, starting the cycle after the accepted request, at addresses base_len to base_len+4. The data is 0x01, 0x03, 0x01, then the period byte, then the offset byte.
- R4: When both want_wide and want_sync are set, only the width message is produced.
- R5: The period byte takes the index n from scratch bits 6:4 and equals floor(25*n/4)+25. When ultra_on is set, this value is halved with the remainder dropped.
- R6: When init_side is set, the synchronous offset byte is 15 on a narrow bus (bus_wide low) and 8 on a wide bus (bus_wide high).
- R7: When init_side is low, the synchronous offset byte is scratch bits 3:0.
- R8: In the cycle after the last write, done is high for exactly one cycle and msg_len equals base_len plus the number of bytes written. msg_len keeps that value until the next completed message.
- R9: A build_req seen while a message is being written, or in its done cycle, makes busy_err high for one cycle in the following cycle. It adds no write, does not change msg_len, and does not repeat done.
- R10: A build_req with neither want_wide nor want_sync set produces no write and no done, and leaves msg_len unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| build_req | input | 1 | Request to build a message, sampled each cycle |
| want_wide | input | 1 | Build a width negotiation message |
| want_sync | input | 1 | Build a synchronous negotiation message |
| scratch | input | 8 | Target byte: bit 7 width flag, bits 6:4 rate index, bits 3:0 offset |
| ultra_on | input | 1 | Ultra speed enabled, halves the period |
| bus_wide | input | 1 | Bus currently 16 bits wide |
| init_side | input | 1 | This side opens the negotiation |
| base_len | input | ADDR_W | Bytes already in the buffer, and the first write address |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | 8 | Buffer write data |
| msg_len | output | ADDR_W | Total buffer length after the last message |
| done | output | 1 | One-cycle pulse when a message is complete |
| busy_err | output | 1 | One-cycle flag for a refused request |

## Verification
The bench sweeps all eight rate indices with ultra speed on and off. A design that computed 25*n/4 in the wrong order, or that dropped bits at the top of the sum, would show a period that is off by one or wraps around. It drives both negotiation kinds at once: a design that ignored the width-first rule would emit five bytes of the wrong message. It also sends second requests during the write burst and during the done cycle. A design that let them through would emit extra writes, restart its addresses or pulse done twice, and one that failed to flag them would leave busy_err silent. Offset selection is covered in both directions and at both bus widths, so that swapping the 8 and 15 limits or ignoring init_side shows up as a wrong last byte.

// File: rtl/neg_pkg.sv
package neg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_DONE = 2'd2
  } neg_state_e;

  typedef enum logic {
    KIND_WIDE = 1'b0,
    KIND_SYNC = 1'b1
  } neg_kind_e;

  localparam int WIDE_LEN = 4;
  localparam int SYNC_LEN = 5;
  localparam int MSG_MAX  = 5;

  localparam logic [7:0] EXT_INTRO  = 8'h01;
  localparam logic [7:0] WIDE_BODY  = 8'h02;
  localparam logic [7:0] SYNC_BODY  = 8'h03;
  localparam logic [7:0] WIDE_CODE  = 8'h03;
  localparam logic [7:0] SYNC_CODE  = 8'h01;
  localparam logic [7:0] PERIOD_ADD = 8'd25;

  // 25*n built as 16n + 8n + n, then quartered, offset and optionally halved
  function automatic logic [7:0] period_from_index(input logic [2:0] idx,
                                                   input logic ultra);
    logic [7:0] prod;
    logic [7:0] sum;
    prod = {1'b0, idx, 4'b0000} + {2'b00, idx, 3'b000} + {5'b00000, idx};
    sum  = {2'b00, prod[7:2]} + PERIOD_ADD;
    return ultra ? {1'b0, sum[7:1]} : sum;
  endfunction

  function automatic logic [7:0] offset_pick(input logic       initiate,
                                             input logic       wide,
                                             input logic [3:0] stored,
                                             input logic [7:0] narrow_max,
                                             input logic [7:0] wide_max);
    if (!initiate) return {4'b0000, stored};
    return wide ? wide_max : narrow_max;
  endfunction

endpackage

// File: rtl/neg_period.sv
module neg_period (
  input  logic [2:0] rate_idx,
  input  logic       ultra,
  output logic [7:0] period
);
  import neg_pkg::*;

  always_comb period = period_from_index(rate_idx, ultra);

endmodule

// File: rtl/neg_byte_sel.sv
module neg_byte_sel (
  input  neg_pkg::neg_kind_e kind,
  input  logic [2:0]         pos,
  input  logic               width_flag,
  input  logic [7:0]         period,
  input  logic [7:0]         offset,
  output logic [7:0]         data
);
  import neg_pkg::*;

  logic [7:0] wide_img [WIDE_LEN];
  logic [7:0] sync_img [SYNC_LEN];
  logic [7:0] slot     [MSG_MAX];
  logic [MSG_MAX-1:0] hit;

  always_comb begin
    wide_img[0] = EXT_INTRO;
    wide_img[1] = WIDE_BODY;
    wide_img[2] = WIDE_CODE;
    wide_img[3] = {7'b0000000, width_flag};
    sync_img[0] = EXT_INTRO;
    sync_img[1] = SYNC_BODY;
    sync_img[2] = SYNC_CODE;
    sync_img[3] = period;
    sync_img[4] = offset;
  end

  // one-hot position decode feeding an AND-OR output mux
  for (genvar g = 0; g < MSG_MAX; g++) begin : g_slot
    assign hit[g] = (pos == 3'(g));
    if (g < WIDE_LEN) begin : g_both
      assign slot[g] = (kind == KIND_WIDE) ? wide_img[g] : sync_img[g];
    end else begin : g_sync_only
      assign slot[g] = (kind == KIND_WIDE) ? 8'h00 : sync_img[g];
    end
  end

  always_comb begin
    data = 8'h00;
    for (int i = 0; i < MSG_MAX; i++) begin
      data = data | (slot[i] & {8{hit[i]}});
    end
  end

endmodule

// File: rtl/neg_seq.sv
module neg_seq #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              want_any,
  input  logic [CNT_W-1:0]  last_idx,
  input  logic [ADDR_W-1:0] base,
  output logic              accept,
  output logic              busy,
  output logic              emit,
  output logic [CNT_W-1:0]  pos,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic [ADDR_W-1:0] len,
  output logic              err
);
  import neg_pkg::*;

  neg_state_e        state;
  logic [CNT_W-1:0]  last_q;
  logic [ADDR_W-1:0] base_q;
  logic              at_last;

  assign busy    = (state != ST_IDLE);
  assign accept  = req && want_any && !busy;
  assign emit    = (state == ST_EMIT);
  assign done    = (state == ST_DONE);
  assign at_last = (pos == last_q);
  assign addr    = base_q + ADDR_W'(pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pos    <= '0;
      last_q <= '0;
      base_q <= '0;
      len    <= '0;
      err    <= 1'b0;
    end else begin
      err <= req && busy;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_EMIT;
            pos    <= '0;
            last_q <= last_idx;
            base_q <= base;
          end
        end
        ST_EMIT: begin
          if (at_last) begin
            state <= ST_DONE;
            len   <= base_q + ADDR_W'(last_q) + ADDR_W'(1);
          end else begin
            pos <= pos + CNT_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/neg_msg_builder.sv
module neg_msg_builder #(
  parameter int ADDR_W        = 8,
  parameter int NARROW_OFFSET = 15,
  parameter int WIDE_OFFSET   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              build_req,
  input  logic              want_wide,
  input  logic              want_sync,
  input  logic [7:0]        scratch,
  input  logic              ultra_on,
  input  logic              bus_wide,
  input  logic              init_side,
  input  logic [ADDR_W-1:0] base_len,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] msg_len,
  output logic              done,
  output logic              busy_err
);
  import neg_pkg::*;

  localparam int CNT_W = $clog2(MSG_MAX);
  localparam logic [7:0] NARROW_MAX = 8'(NARROW_OFFSET);
  localparam logic [7:0] WIDE_MAX   = 8'(WIDE_OFFSET);

  // named internal events, also observed by the bound checker
  logic             accept;
  logic             busy;
  logic             emit;
  logic             want_any;
  neg_kind_e        req_kind;
  logic [CNT_W-1:0] req_last;
  logic [CNT_W-1:0] pos;

  // request fields frozen at acceptance
  neg_kind_e  cap_kind;
  logic [7:0] cap_scr;
  logic       cap_ultra;
  logic       cap_wide;
  logic       cap_init;

  logic [7:0] period;
  logic [7:0] offset;

  assign want_any = want_wide | want_sync;
  assign req_kind = want_wide ? KIND_WIDE : KIND_SYNC;
  assign req_last = (req_kind == KIND_WIDE) ? CNT_W'(WIDE_LEN - 1)
                                            : CNT_W'(SYNC_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_kind  <= KIND_WIDE;
      cap_scr   <= '0;
      cap_ultra <= 1'b0;
      cap_wide  <= 1'b0;
      cap_init  <= 1'b0;
    end else if (accept) begin
      cap_kind  <= req_kind;
      cap_scr   <= scratch;
      cap_ultra <= ultra_on;
      cap_wide  <= bus_wide;
      cap_init  <= init_side;
    end
  end

  neg_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (build_req),
    .want_any (want_any),
    .last_idx (req_last),
    .base     (base_len),
    .accept   (accept),
    .busy     (busy),
    .emit     (emit),
    .pos      (pos),
    .addr     (wr_addr),
    .done     (done),
    .len      (msg_len),
    .err      (busy_err)
  );

  neg_period u_period (
    .rate_idx (cap_scr[6:4]),
    .ultra    (cap_ultra),
    .period   (period)
  );

  assign offset = offset_pick(cap_init, cap_wide, cap_scr[3:0], NARROW_MAX, WIDE_MAX);

  neg_byte_sel u_bytes (
    .kind       (cap_kind),
    .pos        (pos),
    .width_flag (cap_scr[7]),
    .period     (period),
    .offset     (offset),
    .data       (wr_data)
  );

  assign wr_en = emit;

endmodule

// File: rtl/neg_msg_builder_chk.sv
module neg_msg_builder_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              build_req,
  input logic              busy,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [ADDR_W-1:0] msg_len,
  input logic              done,
  input logic              busy_err
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en && $past(wr_en)); // R8

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> wr_addr == ADDR_W'($past(wr_addr) + 1'b1)); // R2

  AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !$past(wr_en)) |-> wr_data == 8'h01); // R3

  AST_LEN_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msg_len) |-> done); // R8

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> $past(build_req && busy)); // R9

endmodule

bind neg_msg_builder neg_msg_builder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/neg_msg_builder_test.sv
`timescale 1ns/1ps
module neg_msg_builder_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       build_req = 1'b0;
  logic       want_wide = 1'b0;
  logic       want_sync = 1'b0;
  logic [7:0] scratch = 8'h00;
  logic       ultra_on = 1'b0;
  logic       bus_wide = 1'b0;
  logic       init_side = 1'b0;
  logic [7:0] base_len = 8'h00;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] msg_len;
  logic       done;
  logic       busy_err;

  int checks = 0;
  int fails  = 0;
  logic [7:0] prev_len = 8'h00;

  always #2 clk = ~clk;

  neg_msg_builder uut (
    .clk(clk), .rst_n(rst_n), .build_req(build_req), .want_wide(want_wide),
    .want_sync(want_sync), .scratch(scratch), .ultra_on(ultra_on),
    .bus_wide(bus_wide), .init_side(init_side), .base_len(base_len),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .msg_len(msg_len),
    .done(done), .busy_err(busy_err)
  );

  // {want_wide, want_sync, init_side, bus_wide, ultra_on, scratch, base_len}
  localparam logic [20:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 8'd1},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'd0},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h35, 8'd2},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h7A, 8'd0},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5C, 8'd3},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h29, 8'd1},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'd2},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0F, 8'd0}
  };

  task automatic check(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int ref_period(input int n, input bit ul);
    int p;
    p = (n * 25) / 4 + 25;
    return ul ? p / 2 : p;
  endfunction

  task automatic run_msg(input bit ww, input bit ws, input bit ini, input bit bw,
                         input bit ul, input logic [7:0] scr, input logic [7:0] base,
                         input int extra_at, input int exp_err);
    int got_a [10];
    int got_d [10];
    int nw = 0;
    int nd = 0;
    int ne = 0;
    int len_done = -1;
    int exp_n;
    int exp_b [5];
    string rq;
    @(negedge clk);
    want_wide = ww; want_sync = ws; init_side = ini; bus_wide = bw;
    ultra_on = ul; scratch = scr; base_len = base; build_req = 1'b1;
    for (int cyc = 1; cyc <= 10; cyc++) begin
      @(negedge clk);
      if (wr_en) begin got_a[nw] = int'(wr_addr); got_d[nw] = int'(wr_data); nw++; end
      if (done) begin nd++; len_done = int'(msg_len); end
      if (busy_err) ne++;
      build_req = (cyc == extra_at);
    end
    build_req = 1'b0;
    exp_b[0] = 1;
    if (ww) begin
      exp_n = 4; exp_b[1] = 2; exp_b[2] = 3; exp_b[3] = int'(scr[7]); exp_b[4] = 0;
      rq = ws ? "R4" : "R2";
    end else if (ws) begin
      exp_n = 5; exp_b[1] = 3; exp_b[2] = 1;
      exp_b[3] = ref_period(int'(scr[6:4]), ul);
      exp_b[4] = ini ? (bw ? 8 : 15) : int'(scr[3:0]);
      rq = "R3";
    end else begin
      exp_n = 0; rq = "R10";
    end
    check({rq, " write count"}, nw, exp_n);
    for (int i = 0; i < exp_n && i < nw; i++) begin
      check({rq, " addr"}, got_a[i], int'(base) + i);
      if (ws && !ww && i == 3) check("R5 period byte", got_d[i], exp_b[i]);
      else if (ws && !ww && i == 4) check(ini ? "R6 offset" : "R7 offset", got_d[i], exp_b[i]);
      else check({rq, " data"}, got_d[i], exp_b[i]);
    end
    check(exp_n == 0 ? "R10 done count" : "R8 done count", nd, exp_n == 0 ? 0 : 1);
    if (exp_n != 0) begin
      check("R8 length at done", len_done, int'(base) + exp_n);
      prev_len = base + 8'(exp_n);
    end
    check(exp_n == 0 ? "R10 length kept" : "R8 length held", int'(msg_len), int'(prev_len));
    check("R9 busy error count", ne, exp_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 wr_en", int'(wr_en), 0);
    check("R1 done", int'(done), 0);
    check("R1 busy_err", int'(busy_err), 0);
    check("R1 msg_len", int'(msg_len), 0);

    for (int v = 0; v < 8; v++) begin
      run_msg(VEC[v][20], VEC[v][19], VEC[v][18], VEC[v][17], VEC[v][16],
              VEC[v][15:8], VEC[v][7:0], 0, 0);
    end

    // R5 every rate index, ultra off and on
    for (int u = 0; u < 2; u++) begin
      for (int n = 0; n < 8; n++) begin
        run_msg(1'b0, 1'b1, 1'b0, 1'b0, u[0], {1'b0, n[2:0], 4'h3}, 8'd4, 0, 0);
      end
    end

    // R9 second request during the write burst and in the done cycle
    run_msg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 8'd6, 2, 1);
    run_msg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'd2, 5, 1);
    run_msg(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h10, 8'd1, 6, 1);

    // R10 request with nothing wanted
    run_msg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'd9, 0, 0);

    // R6 initiated offset on both bus widths at the index extremes
    run_msg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h0F, 8'd0, 0, 0);
    run_msg(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h70, 8'd0, 0, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule